// File: doc/BRIEF.md
# Two-Wire Register-Write Slave with Auto-Increment

This block is the configuration port of an audio tone and volume controller. It watches the open-drain clock and data lines of a two-wire (I2C) bus, oversampled by the system clock, and recognises the start and stop conditions. After a start, it compares the first byte with a fixed device write address. When the address matches, the next byte selects a register and a write mode. Every byte after that is stored in a bank of eight 8-bit control registers. Each byte the block accepts is acknowledged by pulling the data line low during the ninth clock pulse.

The register-select byte carries a 4-bit function index and a step flag. With the flag clear, every data byte in the transfer lands on the same register. With the flag set, the index steps after each byte. Function indices 8 to 15 do not address any register, so bytes sent to them are acknowledged and then dropped. Read transfers, clock stretching and arbitration are not supported. The master need not look at the acknowledge at all, because the slave's timing never depends on it.

Top module: `tonectl_cfg_slave`

## Requirements
- R1: After reset, registers 0 to 7 hold 0x00, 0x00, 0x00, 0x07, 0x07, 0x07, 0x78, 0x78 in that order, the SDA pull-down is released, and no write strobe has been issued.
- R2: A falling SDA while SCL is high is a start, and a rising SDA while SCL is high is a stop. Bits are taken on rising SCL. Bytes clocked while no transfer is open after a stop are neither acknowledged nor stored.
- R3: For each byte it accepts, the block pulls SDA low from the falling SCL edge that ends the eighth bit to the falling SCL edge that ends the ninth clock, so the line reads low while SCL is high on the ninth clock.
- R4: The first byte after a start is acknowledged only if it equals 0x88. Any other value is not acknowledged, and every later byte is ignored and left unacknowledged until the next start.
- R5: The byte after a matching address is always acknowledged. Its bits [3:0] form the register index, bit 4 is the step flag, and bits [7:5] have no effect.
- R6: With the step flag at 0, every data byte of the transfer is written to the selected register, so the last byte sent is the one that remains.
- R7: With the step flag at 1, the first data byte goes to the selected index and each following byte goes to the index one higher. The 4-bit index wraps from 15 to 0.
- R8: Data bytes whose index is 8 to 15 are acknowledged but change no register and produce no write strobe.
- R9: Each stored byte produces a single-cycle write strobe that carries the 3-bit register index, in the same cycle the register output takes the new value. Registers change at no other time.
- R10: A repeated start abandons the transfer in progress and begins a new address phase. A stop abandons it and returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | Enables the open-drain pull-down of SDA for acknowledge |
| reg_flat_o | output | 64 | Register contents; register i sits in bits [8i+7:8i] |
| wr_stb_o | output | 1 | Single-cycle pulse for each stored byte |
| wr_idx_o | output | 3 | Register written at the strobe |

## Verification
The hardest conditions to reach from the ports are the ones where the function index runs past the populated registers. Here bytes must still be acknowledged while nothing is stored, and the index must wrap back into the bank. The bench produces these cases with step-mode transfers that start at index 5 and at index 14. It then checks, one byte at a time, the acknowledge, the strobe count and the register contents. A separate transfer ends with a repeated start in the middle of a stream, followed by clocked bytes sent after a stop, which shows that a framing event cuts off writes that are already in flight.

// File: rtl/tonectl_pkg.sv
package tonectl_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_ADDR,
    RX_SUB,
    RX_DATA,
    RX_SKIP
  } rx_state_e;

  // power-on value of each control register
  function automatic logic [7:0] reg_default(input int idx);
    logic [7:0] v;
    case (idx)
      3, 4, 5: v = 8'h07;
      6, 7:    v = 8'h78;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/tonectl_line_sync.sv
module tonectl_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_chain;
  logic [STAGES-1:0] sda_chain;
  logic              scl_q, sda_q;
  logic              scl_s;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_chain <= '1;
          sda_chain <= '1;
        end else begin
          scl_chain <= scl_i;
          sda_chain <= sda_i;
        end
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_chain <= '1;
          sda_chain <= '1;
        end else begin
          scl_chain <= {scl_chain[STAGES-2:0], scl_i};
          sda_chain <= {sda_chain[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_chain[STAGES-1];
  assign sda_s = sda_chain[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/tonectl_byte_rx.sv
module tonectl_byte_rx
  import tonectl_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter int          IDX_W    = 4,
  parameter logic [7:0]  DEV_ADDR = 8'h88
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data,
  output logic              sda_pull
);
  localparam int CNT_W   = $clog2(DATA_W + 2);
  localparam int INC_BIT = IDX_W;

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] ACK_ON   = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] ACK_OFF  = CNT_W'(DATA_W + 1);

  rx_state_e         state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] byte_in;
  logic [IDX_W-1:0]  idx;
  logic              step;
  logic              accept;

  assign byte_in = {shreg[DATA_W-2:0], sda_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RX_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      idx      <= '0;
      step     <= 1'b0;
      accept   <= 1'b0;
      sda_pull <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state    <= RX_ADDR;
        bit_cnt  <= '0;
        sda_pull <= 1'b0;
        accept   <= 1'b0;
      end else if (stop_det) begin
        state    <= RX_IDLE;
        bit_cnt  <= '0;
        sda_pull <= 1'b0;
        accept   <= 1'b0;
      end else if (state != RX_IDLE) begin
        if (scl_rise && bit_cnt < ACK_ON) begin
          shreg   <= byte_in;
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == LAST_BIT) begin
            case (state)
              RX_ADDR: begin
                if (byte_in == DATA_W'(DEV_ADDR)) begin
                  accept <= 1'b1;
                  state  <= RX_SUB;
                end else begin
                  accept <= 1'b0;
                  state  <= RX_SKIP;
                end
              end
              RX_SUB: begin
                accept <= 1'b1;
                idx    <= byte_in[IDX_W-1:0];
                step   <= byte_in[INC_BIT];
                state  <= RX_DATA;
              end
              RX_DATA: begin
                accept  <= 1'b1;
                wr_en   <= 1'b1;
                wr_idx  <= idx;
                wr_data <= byte_in;
                if (step) idx <= idx + 1'b1;
              end
              default: accept <= 1'b0;
            endcase
          end
        end else if (scl_fall) begin
          if (bit_cnt == ACK_ON) begin
            bit_cnt  <= ACK_OFF;
            sda_pull <= accept;
          end else if (bit_cnt == ACK_OFF) begin
            bit_cnt  <= '0;
            sda_pull <= 1'b0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/tonectl_regfile.sv
module tonectl_regfile
  import tonectl_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 8,
  parameter int IDX_W    = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [NUM_REGS*DATA_W-1:0]   regs_flat,
  output logic                         stb,
  output logic [$clog2(NUM_REGS)-1:0]  stb_idx
);
  localparam int SEL_W = $clog2(NUM_REGS);

  logic             in_range;
  logic [SEL_W-1:0] sel;

  assign in_range = (32'(wr_idx) < NUM_REGS);
  assign sel      = wr_idx[SEL_W-1:0];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs_flat[i*DATA_W +: DATA_W] <= DATA_W'(reg_default(i));
      else if (wr_en && in_range && sel == SEL_W'(i))
        regs_flat[i*DATA_W +: DATA_W] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stb     <= 1'b0;
      stb_idx <= '0;
    end else begin
      stb <= wr_en && in_range;
      if (wr_en && in_range) stb_idx <= sel;
    end
  end

endmodule

// File: rtl/tonectl_cfg_slave.sv
module tonectl_cfg_slave #(
  parameter int         NUM_REGS    = 8,
  parameter int         DATA_W      = 8,
  parameter int         IDX_W       = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] DEV_ADDR    = 8'h88
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         scl_i,
  input  logic                         sda_i,
  output logic                         sda_pull_o,
  output logic [NUM_REGS*DATA_W-1:0]   reg_flat_o,
  output logic                         wr_stb_o,
  output logic [$clog2(NUM_REGS)-1:0]  wr_idx_o
);
  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              rx_wr_en;
  logic [IDX_W-1:0]  rx_wr_idx;
  logic [DATA_W-1:0] rx_wr_data;

  tonectl_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  tonectl_byte_rx #(.DATA_W(DATA_W), .IDX_W(IDX_W), .DEV_ADDR(DEV_ADDR)) rx_i (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .wr_en(rx_wr_en), .wr_idx(rx_wr_idx), .wr_data(rx_wr_data),
    .sda_pull(sda_pull_o)
  );

  tonectl_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) rf_i (
    .clk(clk), .rst(rst), .wr_en(rx_wr_en), .wr_idx(rx_wr_idx),
    .wr_data(rx_wr_data), .regs_flat(reg_flat_o), .stb(wr_stb_o),
    .stb_idx(wr_idx_o)
  );

endmodule

// File: rtl/tonectl_cfg_checker.sv
module tonectl_cfg_checker
  import tonectl_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 8
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        scl_i,
  input logic                        sda_pull_o,
  input logic [NUM_REGS*DATA_W-1:0]  reg_flat_o,
  input logic                        wr_stb_o
);
  logic [NUM_REGS*DATA_W-1:0] dflt;

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++)
      dflt[i*DATA_W +: DATA_W] = DATA_W'(reg_default(i));
  end

  AST_RESET_DEFAULTS: assert property (@(posedge clk) rst |=> (reg_flat_o == dflt && !sda_pull_o && !wr_stb_o)); // R1
  AST_PULL_ON_SCL_LOW: assert property (@(posedge clk) disable iff (rst) $rose(sda_pull_o) |-> !scl_i); // R3
  AST_PULL_OFF_SCL_LOW: assert property (@(posedge clk) disable iff (rst) $fell(sda_pull_o) |-> !scl_i); // R3
  AST_REGS_ONLY_ON_STB: assert property (@(posedge clk) disable iff (rst) !wr_stb_o |-> $stable(reg_flat_o)); // R9
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst) wr_stb_o |=> !wr_stb_o); // R9
  AST_NO_STB_DURING_ACK: assert property (@(posedge clk) disable iff (rst) wr_stb_o |-> !sda_pull_o); // R3

endmodule

bind tonectl_cfg_slave tonectl_cfg_checker #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_pull_o(sda_pull_o),
  .reg_flat_o(reg_flat_o), .wr_stb_o(wr_stb_o)
);

// File: tb/tonectl_cfg_slave_tb_top.sv
module tonectl_cfg_slave_tb_top;
  localparam int H = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_pull_o;
  logic [63:0] reg_flat_o;
  logic       wr_stb_o;
  logic [2:0] wr_idx_o;
  logic       sda_line;

  int checks = 0;
  int fails  = 0;
  int stb_cnt = 0;
  logic [2:0] last_idx = '0;
  logic [7:0] shadow [8];

  assign sda_line = sda_m & ~sda_pull_o;

  always #10 clk = ~clk;

  tonectl_cfg_slave dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull_o), .reg_flat_o(reg_flat_o),
    .wr_stb_o(wr_stb_o), .wr_idx_o(wr_idx_o)
  );

  always @(negedge clk) begin
    if (!rst && wr_stb_o) begin
      stb_cnt++;
      last_idx = wr_idx_o;
    end
  end

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rg(input int i);
    return reg_flat_o[i*8 +: 8];
  endfunction

  task automatic chk_all_regs(input string req);
    for (int i = 0; i < 8; i++) chk(rg(i) == shadow[i], req, rg(i), shadow[i]);
  endtask

  task automatic bus_start();
    scl_m = 1'b0; wcyc(H/2);
    sda_m = 1'b1; wcyc(H/2);
    scl_m = 1'b1; wcyc(H);
    sda_m = 1'b0; wcyc(H);
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; wcyc(H/2);
    sda_m = 1'b0; wcyc(H/2);
    scl_m = 1'b1; wcyc(H);
    sda_m = 1'b1; wcyc(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      scl_m = 1'b0; wcyc(H/2);
      sda_m = b[i]; wcyc(H/2);
      scl_m = 1'b1; wcyc(H);
    end
    scl_m = 1'b0; wcyc(H/2);
    sda_m = 1'b1; wcyc(H/2);
    scl_m = 1'b1; wcyc(H/2);
    acked = !sda_line;
    wcyc(H/2);
  endtask

  task automatic t_reset();
    shadow = '{8'h00, 8'h00, 8'h00, 8'h07, 8'h07, 8'h07, 8'h78, 8'h78};
    chk_all_regs("R1 reset value");
    chk(sda_pull_o == 1'b0, "R1 pull released", sda_pull_o, 0);
    chk(stb_cnt == 0, "R1 no strobe", stb_cnt, 0);
  endtask

  task automatic t_single();
    bit a; int s0;
    s0 = stb_cnt;
    bus_start();
    send_byte(8'h88, a); chk(a, "R4 address ack", a, 1);
    send_byte(8'h02, a); chk(a, "R5 subaddress ack", a, 1);
    send_byte(8'h11, a); chk(a, "R3 data ack", a, 1);
    send_byte(8'h22, a);
    send_byte(8'h33, a); chk(a, "R3 data ack last", a, 1);
    bus_stop();
    shadow[2] = 8'h33;
    chk_all_regs("R6 single register mode");
    chk(stb_cnt - s0 == 3, "R9 strobe count", stb_cnt - s0, 3);
    chk(last_idx == 3'd2, "R9 strobe index", last_idx, 2);
    chk(sda_pull_o == 1'b0, "R3 released after ack", sda_pull_o, 0);
  endtask

  task automatic t_step_high();
    bit a; int s0;
    s0 = stb_cnt;
    bus_start();
    send_byte(8'h88, a);
    send_byte(8'hF5, a); chk(a, "R5 don't-care bits ack", a, 1);
    send_byte(8'hA1, a);
    send_byte(8'hA2, a);
    send_byte(8'hA3, a);
    send_byte(8'hA4, a); chk(a, "R8 ack at index 8", a, 1);
    bus_stop();
    shadow[5] = 8'hA1; shadow[6] = 8'hA2; shadow[7] = 8'hA3;
    chk_all_regs("R7 step mode");
    chk(stb_cnt - s0 == 3, "R8 no strobe past bank", stb_cnt - s0, 3);
    chk(last_idx == 3'd7, "R9 last index", last_idx, 7);
  endtask

  task automatic t_wrap();
    bit a; int s0;
    s0 = stb_cnt;
    bus_start();
    send_byte(8'h88, a);
    send_byte(8'h1E, a);
    send_byte(8'hB0, a); chk(a, "R8 ack index 14", a, 1);
    send_byte(8'hB1, a); chk(a, "R8 ack index 15", a, 1);
    send_byte(8'hB2, a);
    bus_stop();
    shadow[0] = 8'hB2;
    chk_all_regs("R7 wrap to index 0");
    chk(stb_cnt - s0 == 1, "R8 dropped bytes", stb_cnt - s0, 1);
    chk(last_idx == 3'd0, "R7 wrapped index", last_idx, 0);
  endtask

  task automatic t_high_single();
    bit a; int s0;
    s0 = stb_cnt;
    bus_start();
    send_byte(8'h88, a);
    send_byte(8'h09, a);
    send_byte(8'hC0, a); chk(a, "R8 ack index 9", a, 1);
    bus_stop();
    chk_all_regs("R8 index 9 ignored");
    chk(stb_cnt == s0, "R8 no strobe index 9", stb_cnt - s0, 0);
  endtask

  task automatic t_bad_addr();
    bit a; int s0;
    s0 = stb_cnt;
    bus_start();
    send_byte(8'h8A, a); chk(!a, "R4 wrong address no ack", a, 0);
    send_byte(8'h01, a); chk(!a, "R4 later byte no ack", a, 0);
    send_byte(8'h55, a); chk(!a, "R4 data no ack", a, 0);
    bus_stop();
    chk_all_regs("R4 nothing stored");
    chk(stb_cnt == s0, "R4 no strobe", stb_cnt - s0, 0);
  endtask

  task automatic t_abort();
    bit a; int s0;
    s0 = stb_cnt;
    bus_start();
    send_byte(8'h88, a);
    send_byte(8'h13, a);
    send_byte(8'hD0, a);
    bus_start();
    send_byte(8'h88, a); chk(a, "R10 repeated start address", a, 1);
    send_byte(8'h04, a); chk(a, "R10 repeated start sub", a, 1);
    send_byte(8'hD1, a);
    bus_stop();
    shadow[3] = 8'hD0; shadow[4] = 8'hD1;
    chk_all_regs("R10 repeated start");
    chk(stb_cnt - s0 == 2, "R10 strobes", stb_cnt - s0, 2);
    send_byte(8'h88, a); chk(!a, "R2 no start no ack", a, 0);
    send_byte(8'h02, a);
    send_byte(8'hEE, a); chk(!a, "R10 after stop no ack", a, 0);
    chk_all_regs("R2 idle after stop");
    chk(stb_cnt - s0 == 2, "R10 no strobe after stop", stb_cnt - s0, 2);
    bus_stop();
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wcyc(5);
    rst = 1'b0;
    wcyc(5);
    t_reset();
    t_single();
    t_step_high();
    t_wrap();
    t_high_single();
    t_bad_addr();
    t_abort();
    wcyc(20);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule